// File: doc/BRIEF.md
# Fixed-Page Hardware Stack Pointer

This block generates the addresses for a downward-growing hardware stack held in a single 64-byte page. The pointer is 16 bits wide. Its upper ten bits are tied to `0000000011`, so every address lies between `$00C0` and `$00FF`. Only the low six bits move, and they wrap modulo 64. Running past 64 entries overwrites the oldest data and raises no error.

The block accepts single-byte push and pull requests and a command that puts the pointer back to its start. It also runs two multi-byte frame sequences:
- a two-byte frame for a subroutine call or return;
- a five-byte frame for entering or leaving an interrupt.

On each access it drives the address and a write or read strobe. During a frame it also drives a slot code that tells the surrounding datapath which register byte belongs at that address. The memory itself and the data bytes are outside this block.

Top module: `stack_ptr_unit`

## Requirements
- R1: Every address on `addr_o` has bits 15..6 equal to binary 0000000011, so it lies in $00C0..$00FF.
- R2: A push drives `wr_o`=1 with `addr_o` set to the current pointer in that cycle. After the clock edge, the low six bits are one lower, modulo 64, so a push at $00C0 leaves the pointer at $00FF.
- R3: A pull first increments the pointer modulo 64, then reads. It drives `rd_o`=1 with `addr_o` set to pointer+1 in that cycle, and the pointer takes that value after the edge. A pull at $00FF reads $00C0.
- R4: Reset and `sp_rst_i` both set the pointer to $00FF. `sp_rst_i` has priority over every other input. It produces no strobe, and it cancels a running sequence.
- R5: `wr_o` and `rd_o` are never high in the same cycle. When push and pull are both requested while idle, the push is performed.
- R6: A frame request (`seq_req_i`=1) while idle produces no access in that cycle. `busy_o` is then high for exactly 2 cycles when `seq_kind_i`=0 (call) or 5 cycles when `seq_kind_i`=1 (interrupt). There is one access per busy cycle: writes when `seq_dir_i`=0 (stack), reads when `seq_dir_i`=1 (unstack).
- R7: During a frame, `slot_o` gives the byte order. The codes are 0=PC low, 1=PC high, 2=index, 3=accumulator, 4=condition codes.
  - Stacking emits 0,1,2,3,4 for an interrupt and 0,1 for a call.
  - Unstacking emits the reverse order.
  - `slot_o` is 0 when not busy.
- R8: While `busy_o` is high, single push and pull requests are ignored. The pointer moves only by the frame's own accesses.
- R9: 64 consecutive pushes from $00FF visit $00FF down to $00C0. The 65th push writes $00FF again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Single-byte push request |
| pull_i | input | 1 | Single-byte pull request |
| sp_rst_i | input | 1 | Put pointer back to $00FF |
| seq_req_i | input | 1 | Start a frame sequence |
| seq_kind_i | input | 1 | 0 = call frame (2 bytes), 1 = interrupt frame (5 bytes) |
| seq_dir_i | input | 1 | 0 = stack (write), 1 = unstack (read) |
| addr_o | output | 16 | Current stack access address |
| wr_o | output | 1 | Write strobe |
| rd_o | output | 1 | Read strobe |
| busy_o | output | 1 | Frame sequence in progress |
| slot_o | output | 3 | Register byte for the current frame access |

## Verification
Two pairs of functions can collide in one cycle.

- **Reset-pointer against access:** `sp_rst_i` arrives together with a push, or in the middle of a running frame. The bench expects no strobe in that cycle, and the next push must write at $00FF.
- **Frame against single requests:** a push request is held high for the whole of a frame. The bench compares every busy-cycle address and slot with the frame's own sequence. After the frame, one single push must land exactly one below the frame's last address.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int ADDR_W = 16,
  parameter int LOW_W  = 6,
  parameter logic [ADDR_W-LOW_W-1:0] PAGE_HI = 10'b0000000011,
  parameter int CALL_LEN = 2,
  parameter int IRQ_LEN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pull_i,
  input  logic              sp_rst_i,
  input  logic              seq_req_i,
  input  logic              seq_kind_i,
  input  logic              seq_dir_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              busy_o,
  output logic [2:0]        slot_o
);

  localparam logic [LOW_W-1:0] TOP_LOW = '1;
  localparam logic [2:0] CALL_N = 3'(CALL_LEN);
  localparam logic [2:0] IRQ_N  = 3'(IRQ_LEN);

  logic [LOW_W-1:0] low_q;
  logic             busy_q, kind_q, dir_q;
  logic [2:0]       cnt_q;

  wire [2:0] len      = kind_q ? IRQ_N : CALL_N;
  wire       last     = busy_q && (cnt_q == len - 3'd1);
  wire       idle_ok  = !busy_q && !sp_rst_i;
  wire       start    = idle_ok && seq_req_i;
  wire       single   = idle_ok && !seq_req_i;
  wire       do_push  = busy_q ? (!sp_rst_i && !dir_q) : (single && push_i);
  wire       do_pull  = busy_q ? (!sp_rst_i &&  dir_q) : (single && !push_i && pull_i);
  wire [LOW_W-1:0] low_inc = low_q + 1'b1;
  wire [LOW_W-1:0] low_dec = low_q - 1'b1;

  assign addr_o = {PAGE_HI, do_pull ? low_inc : low_q};
  assign wr_o   = do_push;
  assign rd_o   = do_pull;
  assign busy_o = busy_q;
  assign slot_o = !busy_q ? 3'd0 : (dir_q ? (len - 3'd1 - cnt_q) : cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= TOP_LOW;
      busy_q <= 1'b0;
      kind_q <= 1'b0;
      dir_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (sp_rst_i)     low_q <= TOP_LOW;
      else if (do_push) low_q <= low_dec;
      else if (do_pull) low_q <= low_inc;

      if (sp_rst_i) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (start) begin
        busy_q <= 1'b1;
        kind_q <= seq_kind_i;
        dir_q  <= seq_dir_i;
        cnt_q  <= '0;
      end else if (busy_q) begin
        busy_q <= !last;
        cnt_q  <= last ? 3'd0 : cnt_q + 3'd1;
      end
    end
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_o && rd_o));

  // R4
  sp_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_rst_i |=> (low_q == TOP_LOW) && !busy_o);

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && !sp_rst_i) |=> low_q == $past(low_q) - 1'b1);

  // R3
  pull_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o && !sp_rst_i) |=> addr_o[LOW_W-1:0] == $past(addr_o[LOW_W-1:0]) || low_q == $past(addr_o[LOW_W-1:0]));

  // R8
  busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !sp_rst_i) |-> (wr_o ^ rd_o));

  // R6
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !sp_rst_i && seq_req_i) |-> !wr_o && !rd_o ##1 busy_o);

  // R7
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> slot_o < len);

endmodule

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_i = 0, pull_i = 0, sp_rst_i = 0, seq_req_i = 0, seq_kind_i = 0, seq_dir_i = 0;
  logic [15:0] addr_o;
  logic wr_o, rd_o, busy_o;
  logic [2:0] slot_o;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_ptr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pull_i(pull_i), .sp_rst_i(sp_rst_i),
    .seq_req_i(seq_req_i), .seq_kind_i(seq_kind_i), .seq_dir_i(seq_dir_i),
    .addr_o(addr_o), .wr_o(wr_o), .rd_o(rd_o), .busy_o(busy_o), .slot_o(slot_o));

  // op: 0 idle, 1 push, 2 pull, 3 sp reset, 4 push+pull ; {op, addr, wr, rd}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {3'd1, 16'h00FF, 1'b1, 1'b0},
    {3'd1, 16'h00FE, 1'b1, 1'b0},
    {3'd2, 16'h00FE, 1'b0, 1'b1},
    {3'd2, 16'h00FF, 1'b0, 1'b1},
    {3'd2, 16'h00C0, 1'b0, 1'b1},
    {3'd1, 16'h00C0, 1'b1, 1'b0},
    {3'd1, 16'h00FF, 1'b1, 1'b0},
    {3'd3, 16'h00FE, 1'b0, 1'b0},
    {3'd4, 16'h00FF, 1'b1, 1'b0},
    {3'd0, 16'h00FE, 1'b0, 1'b0},
    {3'd2, 16'h00FF, 1'b0, 1'b1},
    {3'd2, 16'h00C0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic pu, input logic pl, input logic sr,
                       input logic rq, input logic kd, input logic dr);
    @(negedge clk);
    push_i = pu; pull_i = pl; sp_rst_i = sr; seq_req_i = rq; seq_kind_i = kd; seq_dir_i = dr;
    #2;
  endtask

  task automatic run_frame(input logic kd, input logic dr, input logic [15:0] a0,
                           input bit hold_push, input string req);
    int n;
    n = kd ? 5 : 2;
    drive(hold_push, 0, 0, 1, kd, dr);
    chk({req, " R6 no access on request"}, {30'd0, wr_o, rd_o}, 32'd0);
    for (int k = 0; k < n; k++) begin
      drive(hold_push, 0, 0, 0, kd, dr);
      chk({req, " R6 busy"}, {31'd0, busy_o}, 32'd1);
      chk({req, " R6 strobe"}, {30'd0, wr_o, rd_o}, dr ? 32'd1 : 32'd2);
      chk({req, " R7 slot"}, {29'd0, slot_o}, dr ? 32'(n - 1 - k) : 32'(k));
      chk({req, " R8 addr"}, {16'd0, addr_o}, dr ? 32'(a0 + 16'(k)) : 32'(a0 - 16'(k)));
    end
    drive(0, 0, 0, 0, 0, 0);
    chk({req, " R6 busy clear"}, {31'd0, busy_o}, 32'd0);
    chk({req, " R7 slot idle"}, {29'd0, slot_o}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0);
    chk("R4 reset addr", {16'd0, addr_o}, 32'h00FF);
    chk("R4 reset strobes/busy", {29'd0, wr_o, rd_o, busy_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      op = VEC[i][20:18];
      drive(op == 1 || op == 4, op == 2 || op == 4, op == 3, 0, 0, 0);
      chk("R2/R3/R4/R5 vector addr", {16'd0, addr_o}, {16'd0, VEC[i][17:2]});
      chk("R2/R3/R4/R5 vector strobes", {30'd0, wr_o, rd_o}, {30'd0, VEC[i][1:0]});
    end

    // R9 and R1: 64 pushes then wrap
    drive(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 65; i++) begin
      drive(1, 0, 0, 0, 0, 0);
      chk("R9 push sequence", {16'd0, addr_o}, 32'(16'h00FF - 16'(i % 64)));
      chk("R1 page window", {22'd0, addr_o[15:6]}, 32'h3);
    end

    // R6/R7 interrupt stack then unstack
    drive(0, 0, 1, 0, 0, 0);
    run_frame(1, 0, 16'h00FF, 0, "irq stack");
    run_frame(1, 1, 16'h00FB, 0, "irq unstack");
    // R8 call frame with push held high throughout
    run_frame(0, 0, 16'h00FF, 1, "call stack push held");
    drive(1, 0, 0, 0, 0, 0);
    chk("R8 push after call frame", {16'd0, addr_o}, 32'h00FD);
    drive(0, 0, 0, 0, 0, 0);
    run_frame(0, 1, 16'h00FD, 0, "call unstack");

    // R4 sp reset mid-frame
    drive(0, 0, 0, 1, 1, 0);
    drive(0, 0, 0, 0, 1, 0);
    drive(0, 0, 1, 0, 0, 0);
    chk("R4 reset mid-frame no strobe", {30'd0, wr_o, rd_o}, 32'd0);
    drive(1, 0, 0, 0, 0, 0);
    chk("R4 busy cancelled", {31'd0, busy_o}, 32'd0);
    chk("R4 push after cancel", {16'd0, addr_o}, 32'h00FF);

    drive(0, 0, 0, 0, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule